// File: doc/BRIEF.md
# Clock Source Selector and Prescaler

This block derives three system clock enables (main, sub-main and auxiliary) from a small set of source clock enables that all live on one fast system clock. Each source is a one-cycle enable pulse that marks an edge of a slower oscillator. Each output picks one source and divides it by a power of two. The auxiliary output also feeds a second divider that drives an enable for an external pin.

One of the selectable sources is made inside the block: the DCO enable divided by its own power-of-two code. A bit in a control word forces the sub-main output low. Three 16-bit control words hold all fields and are reached through a simple port. A write strobe stores the data at the addressed word on a clock edge. The read data follows the address with no clock in between.

A new select or divider value is taken up only when its path is between output periods, so a change never shortens or stretches the period that is already in progress.

Top module: `clksel_top`

## Requirements
- R1: Select code values pick the source: 0 low-frequency crystal, 1 ultra-low-power oscillator, 2 32 kHz reference, 3 DCO, 4 divided DCO, 5 high-frequency crystal; codes 6 and 7 act as 5.
- R2: Word 0 (address 0) holds the selects: main in bits 2:0, sub-main in bits 6:4, auxiliary in bits 10:8. Every other bit reads back as zero.
- R3: Word 1 (address 1) holds the dividers: main in bits 2:0, sub-main in bits 6:4, auxiliary in bits 10:8, auxiliary pin in bits 14:12. Every other bit reads back as zero. Address 3 reads zero.
- R4: A divider code k divides by 2^k for k from 0 to 5, and codes 6 and 7 divide by 32. Once settled, the output pulse spacing equals the source pulse spacing times the divisor.
- R5: Word 2 (address 2) bits 2:0 hold the code of the divided DCO source, which pulses once every 2^k DCO pulses (codes 6 and 7 give 32). Bit 8 is the sub-main off bit. Every other bit reads back as zero.
- R6: `aux_pin_en` is `aux_en` divided again by the auxiliary pin divider code.
- R7: While the sub-main off bit is 1, `sub_en` stays low and the other outputs keep running. Clearing the bit lets the pulses resume.
- R8: A change to a select or divider field takes effect only once the path's count is back at zero. The period in progress keeps its old length.
- R9: After reset all words read zero, and every output follows the low-frequency crystal undivided.
- R10: Each output pulse comes exactly one cycle after a pulse of its selected source. The pin output comes one cycle after an auxiliary pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock shared by all sources |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lf_xtal | input | 1 | Low-frequency crystal enable pulse |
| src_ulp_osc | input | 1 | Ultra-low-power oscillator enable pulse |
| src_ref32k | input | 1 | 32 kHz reference enable pulse |
| src_dco | input | 1 | DCO enable pulse |
| src_hf_xtal | input | 1 | High-frequency crystal enable pulse |
| reg_wr | input | 1 | Write strobe for the control words |
| reg_addr | input | 2 | Control word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| main_en | output | 1 | Main clock enable |
| sub_en | output | 1 | Sub-main clock enable |
| aux_en | output | 1 | Auxiliary clock enable |
| aux_pin_en | output | 1 | Auxiliary pin clock enable |

## Verification
The bench builds the block with its default package values: 3-bit codes, a 5-bit period counter and three output paths. At these values every select and divider code, including the aliased codes 6 and 7, can be swept exhaustively on all three paths. The bench drives the sources with distinct periods of 3, 5, 4, 1 and 2 cycles and sets the divided DCO to a period of 8. With these periods a wrong select shows up as a wrong spacing. The largest period, 256 cycles, stays short enough for a full sweep together with the pin-divider sweep, the mid-period change and the sub-main gating test.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int CODE_W       = 3;
  localparam int MAX_SHIFT    = 5;
  localparam int CNT_W        = MAX_SHIFT;
  localparam int REG_W        = 16;
  localparam int ADDR_W       = 2;
  localparam int NUM_SRC      = 6;
  localparam int NUM_OUT      = 3;
  localparam int FIELD_STRIDE = 4;
  localparam int PIN_LSB      = 12;
  localparam int DCODIV_LSB   = 0;
  localparam int SUBOFF_BIT   = 8;

  localparam logic [REG_W-1:0] SEL_MASK  = 16'h0777;
  localparam logic [REG_W-1:0] DIV_MASK  = 16'h7777;
  localparam logic [REG_W-1:0] MISC_MASK = 16'h0107;

  typedef logic [CODE_W-1:0] code_t;

  // Last count value of a period for a divider code (2^k - 1, saturating at 32).
  function automatic logic [CNT_W-1:0] term_count(code_t d);
    int sh;
    sh = (int'(d) > MAX_SHIFT) ? MAX_SHIFT : int'(d);
    return CNT_W'((1 << sh) - 1);
  endfunction

  // Codes beyond the last real source alias onto the last one.
  function automatic code_t clamp_sel(code_t s, int nsrc);
    if (int'(s) >= nsrc) return code_t'(nsrc - 1);
    return s;
  endfunction
endpackage

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
module clksel_regs
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output code_t             sel_f [NUM_OUT],
  output code_t             div_f [NUM_OUT],
  output code_t             pin_div,
  output code_t             dco_div,
  output logic              sub_off
);
  logic [REG_W-1:0] sel_q, div_q, misc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      div_q  <= '0;
      misc_q <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_W'(0): sel_q  <= wdata & SEL_MASK;
        ADDR_W'(1): div_q  <= wdata & DIV_MASK;
        ADDR_W'(2): misc_q <= wdata & MISC_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(0): rdata = sel_q;
      ADDR_W'(1): rdata = div_q;
      ADDR_W'(2): rdata = misc_q;
      default:    rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_fields
    assign sel_f[i] = sel_q[FIELD_STRIDE*i +: CODE_W];
    assign div_f[i] = div_q[FIELD_STRIDE*i +: CODE_W];
  end

  assign pin_div = div_q[PIN_LSB +: CODE_W];
  assign dco_div = misc_q[DCODIV_LSB +: CODE_W];
  assign sub_off = misc_q[SUBOFF_BIT];
endmodule

// File: rtl/clksel_path.sv
`timescale 1ns/1ps
module clksel_path
  import clksel_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  code_t           sel_req,
  input  code_t           div_req,
  output logic            out_pulse,
  output logic            picked_pulse
);
  localparam int PAD_N = 1 << CODE_W;

  logic [CNT_W-1:0] cnt;
  code_t            act_sel, act_div, eff_sel, eff_div;
  logic [PAD_N-1:0] padded;
  logic             at_boundary, hit;

  // New settings are accepted only with no partial period in flight.
  assign at_boundary = (cnt == '0);
  assign eff_sel     = at_boundary ? sel_req : act_sel;
  assign eff_div     = at_boundary ? div_req : act_div;

  always_comb begin
    padded = '0;
    padded[NSRC-1:0] = src_pulse;
  end

  assign picked_pulse = padded[clamp_sel(eff_sel, NSRC)];
  assign hit          = picked_pulse && (cnt == term_count(eff_div));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_sel   <= '0;
      act_div   <= '0;
      out_pulse <= 1'b0;
    end else begin
      act_sel   <= eff_sel;
      act_div   <= eff_div;
      out_pulse <= hit;
      if (picked_pulse) cnt <= hit ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_lf_xtal,
  input  logic              src_ulp_osc,
  input  logic              src_ref32k,
  input  logic              src_dco,
  input  logic              src_hf_xtal,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              main_en,
  output logic              sub_en,
  output logic              aux_en,
  output logic              aux_pin_en
);
  code_t sel_f [NUM_OUT];
  code_t div_f [NUM_OUT];
  code_t pin_div, dco_div;
  logic  sub_off;

  logic [NUM_SRC-1:0] srcs;
  logic [NUM_OUT-1:0] path_out, path_pick;
  logic               dco_div_pulse, dco_div_pick, pin_pick;

  // Named events for the bound checker.
  logic main_pick, sub_pick, aux_pick;

  clksel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .sel_f(sel_f), .div_f(div_f), .pin_div(pin_div),
    .dco_div(dco_div), .sub_off(sub_off)
  );

  // Internal divided-DCO source.
  clksel_path #(.NSRC(1)) u_dco_div (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_dco), .sel_req('0),
    .div_req(dco_div), .out_pulse(dco_div_pulse), .picked_pulse(dco_div_pick)
  );

  // Index order is the select code order.
  assign srcs = {src_hf_xtal, dco_div_pulse, src_dco, src_ref32k, src_ulp_osc, src_lf_xtal};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    clksel_path #(.NSRC(NUM_SRC)) u_path (
      .clk(clk), .rst_n(rst_n), .src_pulse(srcs), .sel_req(sel_f[i]),
      .div_req(div_f[i]), .out_pulse(path_out[i]), .picked_pulse(path_pick[i])
    );
  end

  // Second divider on the auxiliary output for the pin.
  clksel_path #(.NSRC(1)) u_pin_div (
    .clk(clk), .rst_n(rst_n), .src_pulse(path_out[2]), .sel_req('0),
    .div_req(pin_div), .out_pulse(aux_pin_en), .picked_pulse(pin_pick)
  );

  assign main_pick = path_pick[0];
  assign sub_pick  = path_pick[1];
  assign aux_pick  = path_pick[2];

  assign main_en = path_out[0];
  assign sub_en  = path_out[1] & ~sub_off;
  assign aux_en  = path_out[2];
endmodule

// File: rtl/clksel_checker.sv
`timescale 1ns/1ps
module clksel_checker
  import clksel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              main_en,
  input logic              sub_en,
  input logic              aux_en,
  input logic              aux_pin_en,
  input logic              main_pick,
  input logic              sub_pick,
  input logic              aux_pick,
  input logic              pin_pick,
  input logic              src_dco,
  input logic              dco_div_pulse,
  input logic              sub_off,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata
);
  AST_MAIN_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    main_en |-> $past(main_pick)); // R10
  AST_SUB_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    sub_en |-> $past(sub_pick)); // R10
  AST_AUX_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en |-> $past(aux_pick)); // R10
  AST_PIN_FOLLOWS_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    aux_pin_en |-> ($past(aux_en) && $past(pin_pick))); // R6
  AST_DCODIV_FOLLOWS_DCO: assert property (@(posedge clk) disable iff (!rst_n)
    dco_div_pulse |-> $past(src_dco)); // R5
  AST_SUB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sub_off |-> !sub_en); // R7
  AST_SEL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0)) |-> ((reg_rdata & ~SEL_MASK) == '0)); // R2
  AST_DIV_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |-> ((reg_rdata & ~DIV_MASK) == '0)); // R3
endmodule

bind clksel_top clksel_checker u_chk (
  .clk(clk), .rst_n(rst_n), .main_en(main_en), .sub_en(sub_en), .aux_en(aux_en),
  .aux_pin_en(aux_pin_en), .main_pick(main_pick), .sub_pick(sub_pick),
  .aux_pick(aux_pick), .pin_pick(pin_pick), .src_dco(src_dco),
  .dco_div_pulse(dco_div_pulse), .sub_off(sub_off), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/clksel_top_test.sv
`timescale 1ns/1ps
module clksel_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_lf = 0, s_ulp = 0, s_ref = 0, s_dco = 0, s_hf = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic main_en, sub_en, aux_en, aux_pin_en;
  logic [3:0] outv;
  int checks = 0, failures = 0;
  int g = 0;
  localparam int DCO_CODE = 3;

  always #2 clk = ~clk;

  clksel_top uut (
    .clk(clk), .rst_n(rst_n), .src_lf_xtal(s_lf), .src_ulp_osc(s_ulp),
    .src_ref32k(s_ref), .src_dco(s_dco), .src_hf_xtal(s_hf), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .main_en(main_en), .sub_en(sub_en), .aux_en(aux_en), .aux_pin_en(aux_pin_en)
  );

  assign outv = {aux_pin_en, aux_en, sub_en, main_en};

  // Sources: periods 3, 5, 4, 1, 2 cycles, changed 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    g++;
    s_lf  = (g % 3 == 0);
    s_ulp = (g % 5 == 0);
    s_ref = (g % 4 == 0);
    s_dco = 1'b1;
    s_hf  = (g % 2 == 0);
  end

  function automatic int pow2c(int k);
    return 1 << ((k > 5) ? 5 : k);
  endfunction

  function automatic int src_period(int sel, int dcode);
    case ((sel > 5) ? 5 : sel)
      0: return 3;
      1: return 5;
      2: return 4;
      3: return 1;
      4: return pow2c(dcode);
      default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_check(input int a, input int exp, input string what);
    @(negedge clk);
    reg_addr = 2'(a);
    #0.5;
    check(reg_rdata == 16'(exp), what, int'(reg_rdata), exp);
  endtask

  // Cycles from now until output b next shows a pulse (sampled at negedge).
  task automatic next_pulse(input int b, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!outv[b] && n < 3000);
    if (n >= 3000) check(0, "timeout waiting for pulse", b, 0);
  endtask

  task automatic spacing(input int b, output int gap);
    int d;
    repeat (3) next_pulse(b, d);
    next_pulse(b, gap);
  endtask

  initial begin
    #(4 * 195000);
    check(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap, n, tot, bad;
    bit prev;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R9: reset state
    rd_check(0, 0, "R9 select word after reset");
    rd_check(1, 0, "R9 divider word after reset");
    rd_check(2, 0, "R9 misc word after reset");
    for (int b = 0; b < 4; b++) begin
      spacing(b, gap);
      check(gap == 3, $sformatf("R9 output %0d follows crystal undivided", b), gap, 3);
    end

    // R2 R3 R5: field layout and reserved bits
    wr(0, 16'hFFFF); rd_check(0, 16'h0777, "R2 select word reserved bits zero");
    wr(0, 16'h0531); rd_check(0, 16'h0531, "R2 select fields main=1 sub=3 aux=5");
    wr(1, 16'hFFFF); rd_check(1, 16'h7777, "R3 divider word reserved bits zero");
    wr(1, 16'h4321); rd_check(1, 16'h4321, "R3 divider fields");
    rd_check(3, 0, "R3 unmapped address reads zero");
    wr(2, 16'hFFFF); rd_check(2, 16'h0107, "R5 misc word reserved bits zero");

    // R1 R4: all select and divider codes on all three paths
    wr(2, DCO_CODE);
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        wr(0, s | (s << 4) | (s << 8));
        wr(1, d | (d << 4) | (d << 8));
        for (int b = 0; b < 3; b++) begin
          spacing(b, gap);
          check(gap == src_period(s, DCO_CODE) * pow2c(d),
                $sformatf("R1 R4 out=%0d sel=%0d div=%0d", b, s, d),
                gap, src_period(s, DCO_CODE) * pow2c(d));
        end
      end
    end

    // R5: divided DCO codes
    wr(1, 0);
    wr(0, 16'h0004);
    for (int k = 0; k < 8; k++) begin
      wr(2, k);
      spacing(0, gap);
      check(gap == pow2c(k), $sformatf("R5 divided DCO code %0d", k), gap, pow2c(k));
    end

    // R6: pin divider on auxiliary output
    wr(0, 16'h0300);
    for (int k = 0; k < 8; k++) begin
      wr(1, k << 12);
      spacing(3, gap);
      check(gap == pow2c(k), $sformatf("R6 pin divider code %0d", k), gap, pow2c(k));
    end
    wr(0, 16'h0100);
    wr(1, 16'h3200);
    spacing(3, gap);
    check(gap == 5 * 4 * 8, "R6 pin divider after auxiliary divider", gap, 160);

    // R7: sub-main off
    wr(0, 16'h0033);
    wr(1, 0);
    wr(2, 16'h0100);
    bad = 0; tot = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (sub_en) bad++;
      if (main_en) tot++;
    end
    check(bad == 0, "R7 sub-main low while off", bad, 0);
    check(tot == 40, "R7 main keeps running while sub-main off", tot, 40);
    wr(2, 0);
    spacing(1, gap);
    check(gap == 1, "R7 sub-main resumes after clearing off", gap, 1);

    // R8: change in mid-period keeps the running period
    wr(0, 16'h0003);
    wr(1, 16'h0005);
    next_pulse(0, n);
    next_pulse(0, n);
    tot = 0;
    repeat (10) begin @(negedge clk); tot++; end
    reg_wr = 1; reg_addr = 1; reg_wdata = 0;
    @(negedge clk); tot++;
    reg_wr = 0;
    next_pulse(0, n);
    check(tot + n == 32, "R8 running period completes at old length", tot + n, 32);
    next_pulse(0, n);
    check(n == 1, "R8 new divider applies after boundary", n, 1);

    // R10: output follows selected source by one cycle
    wr(0, 16'h0001);
    wr(1, 0);
    @(negedge clk);
    prev = s_ulp;
    bad = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (main_en != prev) bad++;
      prev = s_ulp;
    end
    check(bad == 0, "R10 main pulse one cycle after source pulse", bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule